// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Unit

This peripheral holds four independent down-counting timers behind one 32-bit word register port. Each timer keeps three values: a load value, a live count and a background reload value. It also has an 8-bit control byte. The control byte picks whether the timer runs, how the count wraps or stops, a clock prescaler, and whether the count is 16 or 32 bits wide. The counters advance only on cycles where the shared tick-enable input is high and the timer's prescaler allows a step. Software that wants an up-counting timebase reads a count and inverts it bitwise.

Each timer can raise a one-bit event when its count steps from 1 to 0. All four events go to a shared interrupt block. That block holds a raw status vector, a mask, and a masked view, and it drives one combined interrupt line. Bit n of the status, mask and clear words belongs to timer n.

Every timer is a three-state machine:
- `ST_OFF`: disabled, count frozen, prescaler cleared.
- `ST_RUN`: counting.
- `ST_HALT`: a one-shot count has reached zero and is held there.

The transitions are:
- `OFF->RUN` when the enable bit is set.
- `RUN->HALT` when a one-shot step happens at a count of 1 or 0.
- `HALT->RUN` on a load write.
- Any state goes to OFF once the enable bit is clear.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low; all timers are in OFF with a count of 0.
- R2: Word map, decoded from address bits [7:2] (bits [1:0] are ignored):
  - Shared registers: mask at 0x00, raw status at 0x04, masked status at 0x08, clear at 0x0C. The clear register is write-only and reads 0.
  - Timer n has its base at 0x10+0x10·n, with load at +0x0, count at +0x4, control at +0x8 and background reload at +0xC.
  - Control reads back its 8 bits zero-extended.
  - Unmapped words read 0.
- R3: A load write sets the count at once, overwrites the background reload value, and makes load read back the written word. A background-reload write changes only the value used at the next periodic reload.
- R4: Control bit 7 enables the timer. While the bit is clear the count does not change except through a load write. Enable takes effect in the cycle after the control write.
- R5: Control bits [3:2] set the prescaler: 00 and 11 step on every tick, 01 on every 16th tick, 10 on every 256th tick. The prescaler is cleared whenever the timer is not in RUN, so it restarts when enable rises.
- R6: Control bit 1 set selects 32-bit counting. Clear selects 16-bit counting: only bits [15:0] count, and the count register reads with bits [31:16] zero.
- R7: With bit 0 and bit 6 clear (free-running), a step from a count of 0 wraps to all ones of the selected width.
- R8: With bit 6 set and bit 0 clear (periodic), a step from a count of 0 loads the background reload value, truncated to the selected width.
- R9: Bit 0 set (one-shot, which takes priority over bit 6) stops the count at 0 and raises the event once. The timer then holds in HALT until a load write.
- R10: The raw status bit of timer n sets on the step where its count goes from 1 to 0, and on no other step.
- R11: Masked status equals raw status AND mask, and `irq` is the OR of the masked bits. Both follow the registers in the same cycle.
- R12: Writing a 1 to clear bit n removes raw bit n. If an event sets the same bit in the cycle of the clear, the bit stays set.
- R13: A load write in the same cycle as a step wins: the count becomes the written value and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Shared timer tick enable |
| bus_addr | input | 8 | Byte address of the word accessed |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two collisions matter here:
- A timer's event setting a raw status bit in the same cycle that software clears that bit.
- A load write landing on a prescaler step.

The first is provoked by running a periodic timer with a reload of 1, so it fires on every other step, while clear writes are interleaved at varying offsets. The second is provoked by writing load values to a divide-by-1 timer while the tick is held high, so every cycle is a step. A behavioural reference model, updated on every clock, judges both collisions by comparing the read port and `irq` each cycle. It expects the raw bit to stay set on a set/clear collision and the written load value to appear on a load/step collision.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
    localparam int unsigned DW       = 32;
    localparam int unsigned NARROW_W = 16;
    localparam int unsigned CTRL_W   = 8;
    localparam int unsigned PRE_MID  = 4;   // log2 of middle divider
    localparam int unsigned PRE_HI   = 8;   // log2 of largest divider
    localparam int unsigned PRE_W    = PRE_HI;

    // control byte bit positions
    localparam int unsigned C_EN    = 7;
    localparam int unsigned C_PER   = 6;
    localparam int unsigned C_PRE_H = 3;
    localparam int unsigned C_PRE_L = 2;
    localparam int unsigned C_WIDE  = 1;
    localparam int unsigned C_ONE   = 0;

    // word index within a group (address bits [3:2])
    localparam logic [1:0] W_LOAD = 2'd0;
    localparam logic [1:0] W_CNT  = 2'd1;
    localparam logic [1:0] W_CTRL = 2'd2;
    localparam logic [1:0] W_BG   = 2'd3;

    localparam logic [1:0] W_MASK  = 2'd0;
    localparam logic [1:0] W_RAW   = 2'd1;
    localparam logic [1:0] W_MSKD  = 2'd2;
    localparam logic [1:0] W_CLEAR = 2'd3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } tmr_st_e;
endpackage

// File: rtl/qdt_prescale.sv
module qdt_prescale
    import qdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       tick_i,
    input  logic [1:0] code_i,
    output logic       step_o
);
    localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << PRE_MID) - 1);
    localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << PRE_HI) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        unique case (code_i)
            2'b01:   lim = LIM_MID;
            2'b10:   lim = LIM_HI;
            default: lim = '0;
        endcase
    end

    assign step_o = active_i && tick_i && (pre_q == lim);

    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= (pre_q == lim) ? '0 : pre_q + 1'b1;
        end
    end

    // R5: prescaler is idle while the timer is not counting
    p_pre_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (pre_q == '0));
endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
    import qdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_load_i,
    input  logic              wr_bg_i,
    input  logic              wr_ctrl_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     load_o,
    output logic [DW-1:0]     bg_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DW-1:0]     count_o,
    output logic              event_o
);
    localparam logic [DW-1:0] NARROW_MASK = DW'((64'd1 << NARROW_W) - 1);

    tmr_st_e            st_q, st_d;
    logic [DW-1:0]      cnt_q, cnt_d;
    logic [DW-1:0]      load_q, bg_q;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [DW-1:0]      wmask, cur;
    logic               step;

    qdt_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (st_q == ST_RUN),
        .tick_i   (tick_i),
        .code_i   (ctrl_q[C_PRE_H:C_PRE_L]),
        .step_o   (step)
    );

    assign wmask = ctrl_q[C_WIDE] ? '1 : NARROW_MASK;
    assign cur   = cnt_q & wmask;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!ctrl_q[C_EN]) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:  st_d = ST_RUN;
                ST_RUN:  if (!wr_load_i && step && ctrl_q[C_ONE] && (cur <= DW'(1)))
                             st_d = ST_HALT;
                ST_HALT: if (wr_load_i) st_d = ST_RUN;
                default: st_d = ST_OFF;
            endcase
        end
    end

    // count datapath and event output
    always_comb begin
        cnt_d   = cnt_q;
        event_o = 1'b0;
        if (wr_load_i) begin
            cnt_d = wdata_i;
        end else if (st_q == ST_RUN && step) begin
            if (cur == '0) begin
                if (ctrl_q[C_ONE])      cnt_d = cnt_q;
                else if (ctrl_q[C_PER]) cnt_d = bg_q & wmask;
                else                    cnt_d = wmask;
            end else begin
                cnt_d   = cur - 1'b1;
                event_o = (cur == DW'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            load_q <= '0;
            bg_q   <= '0;
            ctrl_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_load_i) begin
                load_q <= wdata_i;
                bg_q   <= wdata_i;
            end else if (wr_bg_i) begin
                bg_q <= wdata_i;
            end
            if (wr_ctrl_i) ctrl_q <= wdata_i[CTRL_W-1:0];
        end
    end

    assign load_o  = load_q;
    assign bg_o    = bg_q;
    assign ctrl_o  = ctrl_q;
    assign count_o = cur;

    // R4: a disabled timer keeps its count
    p_off_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && !wr_load_i) |=> $stable(cnt_q));
    // R9: a halted one-shot holds until reloaded
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT && !wr_load_i) |=> $stable(cnt_q));
    // R10: an event leaves the count at zero
    p_event_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> (cnt_q == '0));
    // R13: a load write always lands
    p_load_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
    parameter int unsigned NUM_TMR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mask_i,
    input  logic               wr_clear_i,
    input  logic [NUM_TMR-1:0] wbits_i,
    input  logic [NUM_TMR-1:0] set_i,
    output logic [NUM_TMR-1:0] mask_o,
    output logic [NUM_TMR-1:0] raw_o,
    output logic [NUM_TMR-1:0] masked_o,
    output logic               irq_o
);
    logic [NUM_TMR-1:0] mask_q, raw_q, clr;

    assign clr = wr_clear_i ? wbits_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (wr_mask_i) mask_q <= wbits_i;
            raw_q <= (raw_q & ~clr) | set_i;
        end
    end

    assign mask_o   = mask_q;
    assign raw_o    = raw_q;
    assign masked_o = raw_q & mask_q;
    assign irq_o    = |masked_o;

    // R12: a set in the cycle of a clear survives
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i)));
    // R12: cleared bits without a concurrent set drop
    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set_i)) |=> ((raw_q & $past(clr & ~set_i)) == '0));
endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
    import qdt_pkg::*;
#(
    parameter int unsigned NUM_TMR = 4,
    parameter int unsigned AW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [7:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    localparam int unsigned GRP_W = AW - 4;

    logic [GRP_W-1:0]   grp;
    logic [1:0]         sub;
    logic [DW-1:0]      ld_a  [NUM_TMR];
    logic [DW-1:0]      bg_a  [NUM_TMR];
    logic [DW-1:0]      cnt_a [NUM_TMR];
    logic [CTRL_W-1:0]  ctl_a [NUM_TMR];
    logic [NUM_TMR-1:0] ev, mask_v, raw_v, mskd_v;

    assign grp = bus_addr[AW-1:4];
    assign sub = bus_addr[3:2];

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        logic hit;
        assign hit = bus_wr && (grp == GRP_W'(g + 1));
        qdt_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_en),
            .wr_load_i (hit && sub == W_LOAD),
            .wr_bg_i   (hit && sub == W_BG),
            .wr_ctrl_i (hit && sub == W_CTRL),
            .wdata_i   (bus_wdata),
            .load_o    (ld_a[g]),
            .bg_o      (bg_a[g]),
            .ctrl_o    (ctl_a[g]),
            .count_o   (cnt_a[g]),
            .event_o   (ev[g])
        );
    end

    qdt_irq #(.NUM_TMR(NUM_TMR)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_mask_i  (bus_wr && grp == '0 && sub == W_MASK),
        .wr_clear_i (bus_wr && grp == '0 && sub == W_CLEAR),
        .wbits_i    (bus_wdata[NUM_TMR-1:0]),
        .set_i      (ev),
        .mask_o     (mask_v),
        .raw_o      (raw_v),
        .masked_o   (mskd_v),
        .irq_o      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (grp == '0) begin
            unique case (sub)
                W_MASK:  bus_rdata = DW'(mask_v);
                W_RAW:   bus_rdata = DW'(raw_v);
                W_MSKD:  bus_rdata = DW'(mskd_v);
                default: bus_rdata = '0;
            endcase
        end else begin
            for (int k = 0; k < NUM_TMR; k++) begin
                if (grp == GRP_W'(k + 1)) begin
                    unique case (sub)
                        W_LOAD:  bus_rdata = ld_a[k];
                        W_CNT:   bus_rdata = cnt_a[k];
                        W_CTRL:  bus_rdata = DW'(ctl_a[k]);
                        default: bus_rdata = bg_a[k];
                    endcase
                end
            end
        end
    end

    // R11: the line is high exactly when some masked bit is
    p_irq_line_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw_v & mask_v) != '0));
endmodule

// File: tb/quad_down_timer_tb.sv
module quad_down_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic        wr = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int tick_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    // reference model state
    logic [31:0] m_cnt [4];
    logic [31:0] m_ld  [4];
    logic [31:0] m_bg  [4];
    logic [7:0]  m_ctl [4];
    int          m_st  [4];   // 0 off, 1 run, 2 halt
    int          m_pre [4];
    logic [3:0]  m_mask, m_raw;

    always #2.5 clk = ~clk;

    quad_down_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask_of(input logic [7:0] c);
        return c[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    endfunction

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        int t;
        if (a[7:4] == 4'd0) begin
            case (a[3:2])
                2'd0: return {28'd0, m_mask};
                2'd1: return {28'd0, m_raw};
                2'd2: return {28'd0, m_raw & m_mask};
                default: return 32'd0;
            endcase
        end
        t = int'(a[7:4]) - 1;
        if (t > 3) return 32'd0;
        case (a[3:2])
            2'd0: return m_ld[t];
            2'd1: return m_cnt[t] & wmask_of(m_ctl[t]);
            2'd2: return {24'd0, m_ctl[t]};
            default: return m_bg[t];
        endcase
    endfunction

    // behavioural model, advanced on every clock
    always @(posedge clk) begin
        logic [3:0] sets;
        sets = 4'd0;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cnt[i] = 0; m_ld[i] = 0; m_bg[i] = 0; m_ctl[i] = 0;
                m_st[i] = 0; m_pre[i] = 0;
            end
            m_mask = 0; m_raw = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                bit lw, bw, cw, step;
                int div, nst;
                logic [31:0] msk, cur;
                lw = wr && addr == 8'(16 + 16 * i);
                cw = wr && addr == 8'(24 + 16 * i);
                bw = wr && addr == 8'(28 + 16 * i);
                div = (m_ctl[i][3:2] == 2'b01) ? 16 : (m_ctl[i][3:2] == 2'b10) ? 256 : 1;
                msk = wmask_of(m_ctl[i]);
                cur = m_cnt[i] & msk;
                step = 0;
                if (m_st[i] == 1) begin
                    if (tick_en) begin
                        step = (m_pre[i] == div - 1);
                        m_pre[i] = step ? 0 : (m_pre[i] + 1) % 256;
                    end
                end else m_pre[i] = 0;
                nst = m_st[i];
                if (!m_ctl[i][7]) nst = 0;
                else if (m_st[i] == 0) nst = 1;
                else if (m_st[i] == 1 && !lw && step && m_ctl[i][0] && cur <= 1) nst = 2;
                else if (m_st[i] == 2 && lw) nst = 1;
                if (lw) begin
                    m_cnt[i] = wdata; m_bg[i] = wdata; m_ld[i] = wdata;
                end else if (m_st[i] == 1 && step) begin
                    if (cur == 0) begin
                        if (m_ctl[i][0]) m_cnt[i] = m_cnt[i];
                        else if (m_ctl[i][6]) m_cnt[i] = m_bg[i] & msk;
                        else m_cnt[i] = msk;
                    end else begin
                        m_cnt[i] = cur - 1;
                        if (cur == 1) sets[i] = 1'b1;
                    end
                end
                if (bw) m_bg[i] = wdata;
                if (cw) m_ctl[i] = wdata[7:0];
                m_st[i] = nst;
            end
            if (wr && addr == 8'h00) m_mask = wdata[3:0];
            m_raw = (m_raw & ~((wr && addr == 8'h0C) ? wdata[3:0] : 4'd0)) | sets;
        end
    end

    // tick source and per-clock comparison
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_en = (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? lfsr[0] : 1'b0;
        #2;
        if (rst_n && !done) begin
            chk(rdata === model_rd(addr), "R2", rdata, model_rd(addr));
            chk(irq === |(m_raw & m_mask), "R11", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input string req);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata === model_rd(a), req, rdata, model_rd(a));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            addr = 8'((k % 20) * 4);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int k = 0; k < 20; k++) expect_rd(8'(k * 4), "R1");
        chk(irq === 1'b0, "R1", {31'd0, irq}, 32'd0);
        tick_mode = 1;
        bus_write(8'h00, 32'hF);
        // R7 free-running wrap on timer 0
        bus_write(8'h10, 32'd6);
        bus_write(8'h18, 32'h82);
        idle(12);
        expect_rd(8'h14, "R7");
        expect_rd(8'h04, "R10");
        bus_write(8'h0C, 32'h1);
        expect_rd(8'h04, "R12");
        expect_rd(8'h0C, "R2");
        // R4 disable freezes
        bus_write(8'h18, 32'h02);
        idle(3);  expect_rd(8'h14, "R4");
        idle(3);  expect_rd(8'h14, "R4");
        // R3 / R8 periodic with background reload on timer 1
        bus_write(8'h20, 32'd5);
        bus_write(8'h2C, 32'd9);
        expect_rd(8'h24, "R3");
        expect_rd(8'h20, "R3");
        expect_rd(8'h2C, "R3");
        bus_write(8'h28, 32'hC2);
        idle(20);
        expect_rd(8'h24, "R8");
        bus_write(8'h28, 32'h00);
        // R9 one-shot beats periodic on timer 2
        bus_write(8'h0C, 32'hF);
        bus_write(8'h30, 32'd4);
        bus_write(8'h38, 32'hC3);
        idle(10);
        expect_rd(8'h34, "R9");
        expect_rd(8'h04, "R10");
        bus_write(8'h0C, 32'h4);
        idle(5);
        expect_rd(8'h04, "R9");
        bus_write(8'h30, 32'd3);
        idle(6);
        expect_rd(8'h04, "R9");
        expect_rd(8'h34, "R9");
        // R11 masking
        bus_write(8'h00, 32'h2);
        expect_rd(8'h08, "R11");
        bus_write(8'h00, 32'hF);
        // R6 16-bit, prescale 16, random ticks on timer 3
        tick_mode = 2;
        bus_write(8'h40, 32'h0001_0003);
        bus_write(8'h48, 32'h84);
        expect_rd(8'h44, "R6");
        idle(200);
        expect_rd(8'h44, "R6");
        expect_rd(8'h48, "R2");
        bus_write(8'h48, 32'h00);
        // R5 prescale 256 and reserved code on timer 0
        tick_mode = 1;
        bus_write(8'h10, 32'd2);
        bus_write(8'h18, 32'h8A);
        idle(300); expect_rd(8'h14, "R5");
        idle(600); expect_rd(8'h14, "R5");
        bus_write(8'h18, 32'h0E);
        bus_write(8'h18, 32'h8E);
        idle(4);
        expect_rd(8'h14, "R5");
        // R12 set/clear collisions on timer 1
        bus_write(8'h20, 32'd1);
        bus_write(8'h28, 32'hC2);
        for (int k = 0; k < 20; k++) begin
            bus_write(8'h0C, 32'h2);
            if (k % 3 == 0) idle(1);
            expect_rd(8'h04, "R12");
        end
        // R13 load write colliding with a step on timer 0
        bus_write(8'h18, 32'h82);
        for (int k = 0; k < 5; k++) begin
            bus_write(8'h10, 32'(100 + k));
            expect_rd(8'h14, "R13");
        end
        idle(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        done = 1;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule